// File: doc/BRIEF.md
# Three-Phase Multiplexed Bus Unit

This block sits between a processor core and a narrow external bus. The core asks for a memory read or write by presenting a 14-bit address, an 8-bit write value and a direction flag on a valid/ready handshake. The bus has only one 8-bit pin group, so every transfer is sent as three one-clock phases on those pins. The first phase carries the low address byte. The second carries the upper six address bits, zero-extended. The third carries the data.

A one-hot phase indicator tells external latches which address part is on the pins. An output-enable tells the pad ring when the block drives the pins. The data phase can be stretched by holding a wait input low. Read data is captured at the edge that closes the data phase. A one-cycle completion pulse then reports to the core.

Top module: `mux_bus_unit`

## Requirements
- R1: After a synchronous active-low reset, `phase` is 3'b000, `bus_oe` is 0, `done` is 0, `rd_data` is 0 and `req_ready` is 1. Whenever no phase is active, `bus_oe` stays 0.
- R2: `req_ready` is 1 only while the bus is idle (no phase active). A request is taken at a rising edge where `req_valid` and `req_ready` are both 1.
- R3: In the cycle after acceptance, `phase` is 3'b001 (first phase). It is 3'b010 (second phase) in the next cycle and 3'b100 (data phase) in the cycle after that. `phase` is never more than one-hot.
- R4: During the first phase, `bus_oe` is 1 and `bus_dout` equals address bits [7:0].
- R5: During the second phase, `bus_oe` is 1. `bus_dout[5:0]` equals address bits [13:8] and `bus_dout[7:6]` is 0.
- R6: During the data phase of a write (`req_write`=1 at acceptance), `bus_oe` is 1 and `bus_dout` equals the write data.
- R7: During the data phase of a read, `bus_oe` is 0. `rd_data` takes the value of `bus_din` sampled at the edge that ends the data phase, and changes at no other time.
- R8: If `bus_rdy` is 0 at a rising edge during the data phase, the data phase continues for another cycle. Only the `bus_din` value at the final edge is captured.
- R9: `done` is 1 for exactly one cycle: the cycle after the edge at which the data phase ends with `bus_rdy` = 1. The bus is idle in that cycle.
- R10: Address, write data and direction are held from the accepting edge. Changes on `req_addr`, `req_wdata` or `req_write` during a transfer do not affect the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Bus idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Memory address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last captured read data |
| bus_dout | output | 8 | Value for the shared pins |
| bus_oe | output | 1 | 1 = drive the shared pins, 0 = high impedance |
| bus_din | input | 8 | Value seen on the shared pins |
| bus_rdy | input | 1 | Wait input; 0 stretches the data phase |
| phase | output | 3 | One-hot phase: bit0 low address, bit1 high address, bit2 data |

## Verification
The first phase appears in the cycle after the accepting edge, and the second and third phases follow one cycle apart. `done` and a new `rd_data` appear in the cycle after the closing edge of the data phase, and each extra cycle with `bus_rdy` low adds one cycle. A behavioural model in the bench advances on each rising edge from the same inputs. Every output is compared against it at the following falling edge, so each result is checked exactly in the cycle it is due. The stimulus covers writes, reads, wait stretching with changing pin values, back-to-back requests and core-side inputs that change mid-transfer.

// File: rtl/mbu_pkg.sv
// Shared types for the multiplexed bus unit.
// Assumes one state per bus phase plus an idle state.
package mbu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DATA = 2'd3
    } bus_state_e;

    localparam int PHASE_W = 3;
endpackage

// File: rtl/mbu_seq.sv
// Phase sequencer: steps idle -> low address -> high address -> data,
// holds the data phase while the wait input is low, and produces the
// one-hot phase indicator and the completion pulse.
// Assumes start is only asserted while idle.
module mbu_seq
    import mbu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bus_rdy,
    output bus_state_e          state,
    output logic [PHASE_W-1:0]  phase,
    output logic                finish,
    output logic                done
);
    bus_state_e state_nxt;

    // Next-state selection for the three-phase sequence.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE: if (start) state_nxt = ST_LO;
            ST_LO:   state_nxt = ST_HI;
            ST_HI:   state_nxt = ST_DATA;
            ST_DATA: if (bus_rdy) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Data phase closes at this edge.
    assign finish = (state == ST_DATA) && bus_rdy;

    // Completion pulse, one cycle after the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

    // One-hot phase decode for external latches.
    always_comb begin
        case (state)
            ST_LO:   phase = 3'b001;
            ST_HI:   phase = 3'b010;
            ST_DATA: phase = 3'b100;
            default: phase = 3'b000;
        endcase
    end
endmodule

// File: rtl/mbu_req_hold.sv
// Request holding register: captures the core's address, write data
// and direction when a request is accepted, and keeps them for the
// whole transfer. Assumes load is a single-cycle acceptance strobe.
module mbu_req_hold #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata,
    output logic              hold_write
);
    // Capture request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_wdata <= '0;
            hold_write <= 1'b0;
        end else if (load) begin
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
            hold_write <= in_write;
        end
    end
endmodule

// File: rtl/mbu_pad_ctl.sv
// Pin control: picks the byte placed on the shared pins in each phase,
// decides the drive direction, and captures read data at the closing
// edge of a read's data phase.
// Assumes DATA_W < ADDR_W <= 2*DATA_W.
module mbu_pad_ctl
    import mbu_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              finish,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              hold_write,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] hi_byte;

    // Upper address bits, zero-filled to a full byte when narrower.
    generate
        if (HI_W < DATA_W) begin : g_hi_pad
            assign hi_byte = {{(DATA_W-HI_W){1'b0}}, hold_addr[ADDR_W-1:DATA_W]};
        end else begin : g_hi_full
            assign hi_byte = hold_addr[2*DATA_W-1:DATA_W];
        end
    endgenerate

    // Byte and direction per phase.
    always_comb begin
        bus_dout = '0;
        bus_oe   = 1'b0;
        case (state)
            ST_LO: begin
                bus_dout = hold_addr[DATA_W-1:0];
                bus_oe   = 1'b1;
            end
            ST_HI: begin
                bus_dout = hi_byte;
                bus_oe   = 1'b1;
            end
            ST_DATA: begin
                bus_dout = hold_wdata;
                bus_oe   = hold_write;
            end
            default: ;
        endcase
    end

    // Read data capture at the closing edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_data <= '0;
        else if (finish && !hold_write) rd_data <= bus_din;
    end
endmodule

// File: rtl/mux_bus_unit.sv
// Top of the multiplexed bus unit: accepts a core request while idle and
// moves it over one shared pin group in three phases. The pad drivers
// themselves live outside, steered by bus_oe.
// Assumes the core keeps req_valid asserted until req_ready is seen.
module mux_bus_unit
    import mbu_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_oe,
    input  logic [DATA_W-1:0]   bus_din,
    input  logic                bus_rdy,
    output logic [PHASE_W-1:0]  phase
);
    bus_state_e        state;
    logic              finish;
    logic              accept;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;
    logic              hold_write;

    // Handshake: ready only while idle.
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    mbu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .bus_rdy (bus_rdy),
        .state   (state),
        .phase   (phase),
        .finish  (finish),
        .done    (done)
    );

    mbu_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .in_write   (req_write),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .hold_write (hold_write)
    );

    mbu_pad_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .finish     (finish),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .hold_write (hold_write),
        .bus_din    (bus_din),
        .bus_dout   (bus_dout),
        .bus_oe     (bus_oe),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/mbu_bus_checker.sv
// Protocol checker for the multiplexed bus unit, attached by bind.
// Assumes the default 8-bit pin group.
module mbu_bus_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic [7:0] rd_data,
    input logic [7:0] bus_dout,
    input logic       bus_oe,
    input logic       bus_rdy,
    input logic [2:0] phase
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'b000) |-> !bus_oe); // R1
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (phase == 3'b000)); // R2
    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase)); // R3
    AST_ACCEPT_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (phase == 3'b001)); // R3
    AST_LO_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'b001) |=> (phase == 3'b010)); // R3
    AST_HI_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'b010) |=> (phase == 3'b100)); // R3
    AST_LO_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        phase[0] |-> bus_oe); // R4
    AST_HI_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        phase[1] |-> (bus_oe && bus_dout[7:6] == 2'b00)); // R5
    AST_RD_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(phase[2] && bus_rdy)); // R7
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[2] && !bus_rdy) |=> (phase[2] && !done)); // R8
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[2] && bus_rdy) |=> (done && phase == 3'b000)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
endmodule

bind mux_bus_unit mbu_bus_checker u_chk (.*);

// File: tb/mux_bus_unit_test.sv
// Bench for the multiplexed bus unit: a behavioural model advanced at
// each rising edge, compared against every output at each falling edge.
module mux_bus_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [13:0] req_addr;
    logic [7:0]  req_wdata;
    logic        done;
    logic [7:0]  rd_data, bus_dout, bus_din;
    logic        bus_oe, bus_rdy;
    logic [2:0]  phase;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit started = 0;

    // Model state.
    int          m_ph = 0;
    int          m_t3 = 0;
    logic [13:0] m_addr = '0;
    logic [7:0]  m_wd = '0;
    logic        m_wr = 1'b0;
    logic        m_done = 1'b0;
    logic [7:0]  m_rd = '0;

    mux_bus_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .bus_rdy(bus_rdy), .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp_v);
        end
    endtask

    // Model update on each rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_t3 = 0; m_done = 0; m_rd = '0;
            m_addr = '0; m_wd = '0; m_wr = 0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (req_valid) begin
                    m_addr = req_addr; m_wd = req_wdata; m_wr = req_write; m_ph = 1;
                end
                1: m_ph = 2;
                2: begin m_ph = 3; m_t3 = 0; end
                default: begin
                    if (bus_rdy) begin
                        if (!m_wr) m_rd = bus_din;
                        m_done = 1; m_ph = 0;
                    end else m_t3++;
                end
            endcase
        end
        if (cyc > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Compare all outputs against the model at each falling edge.
    always @(negedge clk) begin
        if (started) begin
            logic [7:0] exp_ph, exp_d;
            logic       exp_oe;
            string      ph_tag, oe_tag, d_tag;
            exp_ph = (m_ph == 1) ? 8'd1 : (m_ph == 2) ? 8'd2 : (m_ph == 3) ? 8'd4 : 8'd0;
            ph_tag = !rst_n ? "R1" : (m_ph == 3 && m_t3 > 0) ? "R8" : "R3";
            chk(ph_tag, {5'b0, phase}, exp_ph);
            exp_oe = (m_ph == 1) || (m_ph == 2) || (m_ph == 3 && m_wr);
            if (!rst_n || m_ph == 0) oe_tag = "R1";
            else if (m_ph == 1)      oe_tag = "R4";
            else if (m_ph == 2)      oe_tag = "R5";
            else                     oe_tag = m_wr ? "R6" : "R7";
            chk(oe_tag, {7'b0, bus_oe}, {7'b0, exp_oe});
            if (exp_oe) begin
                exp_d = (m_ph == 1) ? m_addr[7:0] :
                        (m_ph == 2) ? {2'b00, m_addr[13:8]} : m_wd;
                d_tag = (req_addr != m_addr || req_wdata != m_wd) ? "R10" : oe_tag;
                chk(d_tag, bus_dout, exp_d);
            end
            chk(!rst_n ? "R1" : "R2", {7'b0, req_ready}, {7'b0, (m_ph == 0)});
            chk(!rst_n ? "R1" : "R9", {7'b0, done}, {7'b0, m_done});
            chk(!rst_n ? "R1" : "R7", rd_data, m_rd);
        end
    end

    // One transfer, driven relative to falling edges.
    task automatic xfer(input bit wr, input logic [13:0] a, input logic [7:0] wd,
                        input logic [7:0] din, input int waits, input bit keep_valid,
                        input bit scramble);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        while (m_ph != 1) @(negedge clk);
        #1;
        if (!keep_valid) req_valid = 0;
        if (scramble) begin  // R10: core-side inputs change mid-transfer
            req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
        end
        @(negedge clk);      // second phase
        @(negedge clk);      // data phase
        #1;
        for (int i = 0; i < waits; i++) begin  // R8: stretched data phase
            bus_rdy = 0; bus_din = ~din ^ 8'(i);
            @(negedge clk); #1;
        end
        bus_rdy = 1; bus_din = din;
        @(negedge clk); #1;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        bus_din = 8'h00; bus_rdy = 1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        repeat (2) @(negedge clk);
        #1;
        xfer(1'b1, 14'h3FFF, 8'hA5, 8'h00, 0, 0, 0);
        xfer(1'b0, 14'h0000, 8'h00, 8'h3C, 0, 0, 0);
        xfer(1'b0, 14'h1234, 8'h11, 8'h5A, 3, 0, 0);
        xfer(1'b1, 14'h2A81, 8'h00, 8'h99, 2, 0, 1);
        xfer(1'b0, 14'h3F00, 8'h22, 8'hFF, 0, 1, 0);
        xfer(1'b1, 14'h00FF, 8'h7E, 8'h00, 0, 1, 0);
        xfer(1'b0, 14'h0155, 8'h33, 8'hC3, 1, 0, 1);
        req_valid = 0;
        repeat (4) @(negedge clk);
        #1 rst_n = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule